// File: doc/BRIEF.md
# Random-Coefficient Linear Coding Pipeline

This block merges two 64-bit payload words into one 72-bit coded word. Each word is scaled by its own 8-bit pseudo-random coefficient, and the two products are summed. A downstream decoder can only recover the two payloads if it knows the coefficients. For that reason, the coefficients that produced each coded word leave the block on the same cycle as that word, ready to be written into a packet header. Narrowing the result back to 64 bits and building the header happen outside this block.

Coefficients come from an internal 16-bit maximal-length shift-register generator. A draw request makes the generator take two steps in one cycle, giving a fresh coefficient pair. A payload pair presented in that cycle uses the fresh pair. A payload pair presented with no draw request reuses the last pair drawn. The arithmetic runs through three register stages: multiply, add, output. The valid flag and the coefficients travel with the data through all three.

Top module: `lcode_pipe`

## Requirements
- R1: The generator state changes only in cycles with `draw_en` high. A valid pair presented with `draw_en` low is coded with the coefficient pair most recently drawn. After reset, before any draw, that pair is 1 and 1.
- R2: The generator is a left-shifting 16-bit Fibonacci register seeded with 16'hACE1. Its new bit 0 is the XOR of state bits 15, 13, 12 and 10. A draw takes two steps. Coefficient A is bits 7:0 after the first step, and coefficient B is bits 7:0 after the second step.
- R3: A drawn coefficient whose low byte is zero is replaced by 1, so neither coefficient is ever zero.
- R4: The coded word equals A*pay_a + B*pay_b modulo 2^72. The carry out of bit 71 is discarded.
- R5: `coded_valid` is high in exactly the third cycle after a cycle with `in_valid` high, and is low otherwise.
- R6: `out_coef_a` and `out_coef_b` carry the coefficients that produced the word on `coded_word`, in the same cycle.
- R7: During and right after reset, `coded_valid`, `coded_word` and both output coefficients are zero.
- R8: While `coded_valid` is low, `coded_word` and both output coefficients hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| draw_en | input | 1 | Draw a fresh coefficient pair this cycle |
| in_valid | input | 1 | `pay_a` and `pay_b` hold a pair to code |
| pay_a | input | 64 | Payload word of channel A |
| pay_b | input | 64 | Payload word of channel B |
| coded_word | output | 72 | Linear combination of the two payloads |
| coded_valid | output | 1 | `coded_word` is new this cycle |
| out_coef_a | output | 8 | Coefficient used on channel A |
| out_coef_b | output | 8 | Coefficient used on channel B |

## Verification
The hardest case to reach from the ports is a drawn coefficient whose low byte comes out zero, because the bench cannot set the generator state. Such draws occur only at fixed points along the generator's sequence. The stimulus therefore issues thousands of draws, mostly together with valid pairs. A bench model of the generator flags each substituted coefficient, so the check for that output cycle is tagged as the substitution case. The bench also counts these cycles and requires at least one. The carry out of bit 71 is reached by streaming all-ones payloads while drawing continuously, until both coefficients happen to be large.

// File: rtl/lcode_pkg.sv
package lcode_pkg;
  localparam int unsigned LFSR_W = 16;
  // feedback from state bits 15, 13, 12, 10
  localparam logic [LFSR_W-1:0] TAP_MASK = 16'hB400;
  localparam logic [LFSR_W-1:0] SEED_DEF = 16'hACE1;

  function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] s,
                                                     input logic [LFSR_W-1:0] taps);
    return {s[LFSR_W-2:0], ^(s & taps)};
  endfunction
endpackage

// File: rtl/coef_draw.sv
module coef_draw #(
  parameter int unsigned COEF_W = 8,
  parameter logic [lcode_pkg::LFSR_W-1:0] SEED = lcode_pkg::SEED_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              draw_en,
  output logic [COEF_W-1:0] coef_a,
  output logic [COEF_W-1:0] coef_b
);
  import lcode_pkg::*;

  logic [LFSR_W-1:0] state, step_one, step_two;
  logic [COEF_W-1:0] raw_a, raw_b, fresh_a, fresh_b, held_a, held_b;
  logic              fix_a, fix_b;

  function automatic logic [COEF_W-1:0] nonzero(input logic [COEF_W-1:0] c);
    return (c == '0) ? COEF_W'(1) : c;
  endfunction

  always_comb begin
    step_one = lfsr_advance(state, TAP_MASK);
    step_two = lfsr_advance(step_one, TAP_MASK);
    raw_a    = step_one[COEF_W-1:0];
    raw_b    = step_two[COEF_W-1:0];
    fix_a    = (raw_a == '0);
    fix_b    = (raw_b == '0);
    fresh_a  = nonzero(raw_a);
    fresh_b  = nonzero(raw_b);
    coef_a   = draw_en ? fresh_a : held_a;
    coef_b   = draw_en ? fresh_b : held_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEED;
      held_a <= COEF_W'(1);
      held_b <= COEF_W'(1);
    end else if (draw_en) begin
      state  <= step_two;
      held_a <= fresh_a;
      held_b <= fresh_b;
    end
  end

  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !draw_en |=> $stable(state)) else $error("generator moved without draw"); // R1
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0) else $error("generator locked at zero"); // R2
  AST_COEF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_a != '0) && (coef_b != '0)) else $error("zero coefficient issued"); // R3
  AST_FIX_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    draw_en && !fix_a |-> coef_a == raw_a) else $error("coefficient altered"); // R3
endmodule

// File: rtl/scale_lane.sv
module scale_lane #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned COEF_W = 8,
  localparam int unsigned PROD_W = WORD_W + COEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic [COEF_W-1:0] coef,
  output logic [PROD_W-1:0] product
);
  function automatic logic [PROD_W-1:0] scale(input logic [WORD_W-1:0] w,
                                              input logic [COEF_W-1:0] c);
    return PROD_W'(w) * PROD_W'(c);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    product <= '0;
    else if (load) product <= scale(word, coef);
  end
endmodule

// File: rtl/mix_adder.sv
module mix_adder #(
  parameter int unsigned SUM_W = 72
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SUM_W-1:0] term_a,
  input  logic [SUM_W-1:0] term_b,
  output logic [SUM_W-1:0] sum
);
  logic [SUM_W:0] wide_sum;

  function automatic logic [SUM_W:0] add_full(input logic [SUM_W-1:0] x,
                                              input logic [SUM_W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  assign wide_sum = add_full(term_a, term_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sum <= '0;
    else if (load) sum <= wide_sum[SUM_W-1:0];
  end
endmodule

// File: rtl/lcode_pipe.sv
module lcode_pipe #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned COEF_W = 8,
  parameter logic [lcode_pkg::LFSR_W-1:0] SEED = lcode_pkg::SEED_DEF,
  localparam int unsigned CODE_W = WORD_W + COEF_W,
  localparam int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              draw_en,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] pay_a,
  input  logic [WORD_W-1:0] pay_b,
  output logic [CODE_W-1:0] coded_word,
  output logic              coded_valid,
  output logic [COEF_W-1:0] out_coef_a,
  output logic [COEF_W-1:0] out_coef_b
);
  logic [COEF_W-1:0] cur_a, cur_b;
  logic [WORD_W-1:0] lane_word [LANES];
  logic [COEF_W-1:0] lane_coef [LANES];
  logic [CODE_W-1:0] lane_prod [LANES];
  logic              s1_vld, s2_vld;
  logic [COEF_W-1:0] s1_ca, s1_cb, s2_ca, s2_cb;
  logic [CODE_W-1:0] s2_sum;

  coef_draw #(.COEF_W(COEF_W), .SEED(SEED)) u_draw (
    .clk(clk), .rst_n(rst_n), .draw_en(draw_en),
    .coef_a(cur_a), .coef_b(cur_b)
  );

  assign lane_word[0] = pay_a;
  assign lane_word[1] = pay_b;
  assign lane_coef[0] = cur_a;
  assign lane_coef[1] = cur_b;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    scale_lane #(.WORD_W(WORD_W), .COEF_W(COEF_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .load(in_valid),
      .word(lane_word[g]), .coef(lane_coef[g]), .product(lane_prod[g])
    );
  end

  mix_adder #(.SUM_W(CODE_W)) u_mix (
    .clk(clk), .rst_n(rst_n), .load(s1_vld),
    .term_a(lane_prod[0]), .term_b(lane_prod[1]), .sum(s2_sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
      coded_valid <= 1'b0;
    end else begin
      s1_vld <= in_valid;
      s2_vld <= s1_vld;
      coded_valid <= s2_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_ca <= '0; s1_cb <= '0;
      s2_ca <= '0; s2_cb <= '0;
      out_coef_a <= '0; out_coef_b <= '0;
      coded_word <= '0;
    end else begin
      if (in_valid) begin
        s1_ca <= cur_a; s1_cb <= cur_b;
      end
      if (s1_vld) begin
        s2_ca <= s1_ca; s2_cb <= s1_cb;
      end
      if (s2_vld) begin
        out_coef_a <= s2_ca; out_coef_b <= s2_cb;
        coded_word <= s2_sum;
      end
    end
  end

  AST_PIPE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> s2_vld) else $error("stage 2 lost a word"); // R5
  AST_PIPE_NO_GHOST: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_vld |=> !coded_valid) else $error("output valid without source"); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !coded_valid |-> $stable(coded_word) && $stable(out_coef_a) && $stable(out_coef_b))
    else $error("output changed while idle"); // R8
  AST_OUT_COEF_NZ: assert property (@(posedge clk) disable iff (!rst_n)
    coded_valid |-> (out_coef_a != '0) && (out_coef_b != '0))
    else $error("zero coefficient at output"); // R3
endmodule

// File: tb/lcode_pipe_tb.sv
module lcode_pipe_tb_top;
  localparam time CLK_PERIOD = 8ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        draw_en = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] pay_a = '0;
  logic [63:0] pay_b = '0;
  logic [71:0] coded_word;
  logic        coded_valid;
  logic [7:0]  out_coef_a, out_coef_b;

  int n_checks = 0;
  int n_fails = 0;
  int n_fixes = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcode_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .draw_en(draw_en), .in_valid(in_valid),
    .pay_a(pay_a), .pay_b(pay_b), .coded_word(coded_word),
    .coded_valid(coded_valid), .out_coef_a(out_coef_a), .out_coef_b(out_coef_b)
  );

  // bench model state
  logic [15:0] m_state = 16'hACE1;
  logic [7:0]  m_held_a = 8'd1, m_held_b = 8'd1;
  logic [71:0] m_last_w = '0;
  logic [7:0]  m_last_a = '0, m_last_b = '0;
  bit          rv [4];
  logic [71:0] rw [4];
  logic [7:0]  ra [4], rb [4];
  string       rt [4];
  int          cyc = 0;

  function automatic logic [15:0] m_step(input logic [15:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return {s[14:0], fb};
  endfunction

  // shift-and-add product, reduced to 72 bits
  function automatic logic [71:0] m_mac(input logic [7:0] ca, input logic [63:0] pa,
                                        input logic [7:0] cb, input logic [63:0] pb);
    logic [71:0] acc;
    acc = '0;
    for (int i = 0; i < 8; i++) begin
      if (ca[i]) acc = acc + ({8'd0, pa} << i);
      if (cb[i]) acc = acc + ({8'd0, pb} << i);
    end
    return acc;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [71:0] act,
                     input logic [71:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // compare outputs with the entry stored three cycles earlier
  task automatic check_outputs();
    int k;
    k = (cyc + 1) % 4;
    chk(coded_valid == rv[k], "R5 valid", 72'(coded_valid), 72'(rv[k]));
    chk(coded_word == rw[k], rv[k] ? "R4 word" : "R8 word hold", coded_word, rw[k]);
    chk(out_coef_a == ra[k] && out_coef_b == rb[k], rt[k],
        {56'd0, out_coef_a, out_coef_b}, {56'd0, ra[k], rb[k]});
  endtask

  task automatic cycle(input bit d, input bit v, input logic [63:0] a, input logic [63:0] b);
    logic [15:0] s1, s2;
    logic [7:0] ca, cb;
    bit fixed;
    string tag;
    @(negedge clk);
    check_outputs();
    draw_en = d; in_valid = v; pay_a = a; pay_b = b;
    fixed = 0;
    if (d) begin
      s1 = m_step(m_state);
      s2 = m_step(s1);
      ca = s1[7:0]; cb = s2[7:0];
      if (ca == 0) begin ca = 8'd1; fixed = 1; end
      if (cb == 0) begin cb = 8'd1; fixed = 1; end
      m_state = s2; m_held_a = ca; m_held_b = cb;
      tag = fixed ? "R3 R6 coef" : "R2 R6 coef";
    end else begin
      ca = m_held_a; cb = m_held_b;
      tag = "R1 R6 coef";
    end
    if (v) begin
      m_last_w = m_mac(ca, a, cb, b);
      m_last_a = ca; m_last_b = cb;
      if (fixed) n_fixes++;
    end else tag = "R8 coef hold";
    rv[cyc % 4] = v; rw[cyc % 4] = m_last_w;
    ra[cyc % 4] = m_last_a; rb[cyc % 4] = m_last_b; rt[cyc % 4] = tag;
    cyc++;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      rv[i] = 0; rw[i] = '0; ra[i] = '0; rb[i] = '0; rt[i] = "R7 coef";
    end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(coded_valid == 0 && coded_word == 0, "R7 reset", coded_word, '0);
    chk(out_coef_a == 0 && out_coef_b == 0, "R7 reset coef",
        {56'd0, out_coef_a, out_coef_b}, '0);
    rst_n = 1'b1;
    // R1: valid pair before any draw uses 1 and 1
    cycle(0, 1, 64'd5, 64'd7);
    // R2: first draws, small payloads
    cycle(1, 1, 64'd2, 64'd3);
    cycle(1, 1, 64'd1, 64'd1);
    // R1: reuse without draw, idle draws then reuse
    cycle(0, 1, 64'd100, 64'd200);
    cycle(1, 0, '0, '0);
    cycle(1, 0, '0, '0);
    cycle(0, 0, '0, '0);
    cycle(0, 1, 64'hFFFF_0000_FFFF_0000, 64'h1234_5678_9ABC_DEF0);
    cycle(0, 0, '0, '0);
    cycle(0, 0, '0, '0);
    cycle(0, 0, '0, '0);
    // zero payloads
    cycle(1, 1, '0, '0);
    // R4: all-ones stream for truncation of the carry
    for (int i = 0; i < 300; i++) cycle(1, 1, '1, '1);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      bit d, v;
      logic [63:0] a, b;
      d = ($urandom % 10) < 7;
      v = ($urandom % 10) < 7;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if ($urandom % 16 == 0) a = '1;
      if ($urandom % 16 == 0) b = '0;
      cycle(d, v, a, b);
    end
    for (int i = 0; i < 4; i++) cycle(0, 0, '0, '0);
    chk(n_fixes > 0, "R3 substitution reached", 72'(n_fixes), 72'd1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule